// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel Pair

This block copies a linear buffer from one memory region to another. It has two channels. A read channel fetches elements from memory and a write channel stores them. A small internal FIFO connects the two. Each channel has its own register set: a base address, an element count, a byte stride and a configuration word. Software programs both channels through a single register write port. The read channel is enabled first and the write channel second. Each channel walks its buffer linearly, moves its address by the stride after every accepted access, and returns to idle once its count reaches zero.

Completion belongs to the write channel alone. A sticky done flag sets when the write channel finishes, and software clears it by writing 1. The interrupt line is the done flag gated by the write channel's interrupt enable. A sync bit chooses when completion is reported. When sync is set, completion waits until memory has acknowledged every write. When sync is clear, completion follows the last accepted write request. Before a channel starts, its configuration is checked: direction, stop flow mode, bus size limit, and agreement of the two bus-size fields. A configuration that fails the check raises a sticky error flag and the channel stays idle.

Top module: `mdma_pair`

## Requirements
- R1: A started channel performs exactly `count` memory accesses. A count of zero completes with no access at all.
- R2: The k-th access of a channel uses address base + k*stride, where stride is in bytes. The size output carries the memory-size field: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes.
- R3: The write channel stores the elements in the same order the read channel received them.
- R4: The configuration word is laid out as bit 0 enable, bit 1 direction (0 = memory read, 1 = memory write), bit 2 flow (1 = stop mode), bits 4:3 memory size, bits 6:5 bus size, bit 7 sync, bit 8 interrupt enable. Writing it with enable set while the channel is idle starts the channel. Register selects are 0 address, 1 count, 2 stride, 3 configuration, 4 status.
- R5: A start is rejected, `cfg_err` is set and the channel stays idle when any of these holds: the bus size is above 2; the direction bit does not match the channel (read channel 0, write channel 1); flow is not stop mode; or the write channel's bus size differs from the read channel's.
- R6: With sync set, `done` rises only after every write has been acknowledged. With sync clear, `done` may rise while acknowledges are still outstanding.
- R7: `done` and `cfg_err` are sticky. A status write clears `done` when data bit 0 is 1 and clears `cfg_err` when data bit 1 is 1.
- R8: `irq` equals `done` AND the write channel's interrupt enable bit.
- R9: Writes to the address, count or stride registers of a busy channel are ignored.
- R10: After its work unit a channel returns to idle, and its busy output goes low.
- R11: The read channel keeps at most one read outstanding. It stops issuing reads while the FIFO is full, and the FIFO never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | 1 | Channel select: 0 read, 1 write |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_size | output | 2 | Read access size code |
| rd_gnt | input | 1 | Read request accepted this cycle |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_size | output | 2 | Write access size code |
| wr_data | output | 32 | Write data |
| wr_gnt | input | 1 | Write request accepted this cycle |
| wr_ack | input | 1 | Write completed by memory |
| src_busy | output | 1 | Read channel not idle |
| dst_busy | output | 1 | Write channel not idle |
| done | output | 1 | Sticky completion flag |
| cfg_err | output | 1 | Sticky configuration error flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: a 4-entry FIFO, 16-bit counts and a bus size limit of 2. At these sizes, one sweep covers every memory size, counts from zero up to a few times the FIFO depth, both sync settings and two write-grant patterns. One of those grant patterns is slow enough to fill the FIFO and stall the read channel. Each accepted access is checked against an address and a data value computed from base, stride and index. A write-acknowledge latency of ten cycles separates the two sync behaviours in time, so the bench can see which one the design follows.

// File: rtl/mdma_pkg.sv
// Shared types for the memory-to-memory DMA pair.
// Assumes the configuration word occupies the low CFG_W bits of a register write.
package mdma_pkg;
    localparam int CFG_W = 9;

    localparam logic [2:0] SEL_ADDR   = 3'd0;
    localparam logic [2:0] SEL_CNT    = 3'd1;
    localparam logic [2:0] SEL_STRIDE = 3'd2;
    localparam logic [2:0] SEL_CFG    = 3'd3;
    localparam logic [2:0] SEL_STAT   = 3'd4;

    typedef enum logic [1:0] {CH_IDLE, CH_RUN, CH_DRAIN, CH_DONE} ch_state_t;

    // bit 0 is en, bit 8 is irq_en
    typedef struct packed {
        logic       irq_en;
        logic       sync;
        logic [1:0] psize;
        logic [1:0] msize;
        logic       flow;
        logic       dir;
        logic       en;
    } cfg_t;
endpackage

// File: rtl/mdma_fifo.sv
// Small synchronous FIFO joining the read and write channels.
// Assumes the producer never pushes when full and the consumer never pops when empty.
module mdma_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] pdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int NW = PW + 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [NW-1:0] n_q;

    assign full  = (n_q == NW'(DEPTH));
    assign empty = (n_q == '0);
    assign head  = mem_q[rp_q];

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            n_q  <= '0;
        end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            n_q <= n_q + NW'(push) - NW'(pop);
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= pdata;
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/mdma_chan.sv
// One DMA channel: register set, linear address/count walker and IDLE/RUN/DRAIN/DONE FSM.
// IS_DST selects the write channel (bus-size match check, sync drain); otherwise the read
// channel, which keeps at most one access outstanding. Assumes mem_resp arrives in order.
module mdma_chan import mdma_pkg::*; #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int OW        = 8,
    parameter bit IS_DST    = 1'b0,
    parameter int MAX_PSIZE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    sel,
    input  logic [31:0]   wdata,
    input  logic [1:0]    peer_psize,
    input  logic          xfer_ok,
    input  logic          mem_gnt,
    input  logic          mem_resp,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [1:0]    psize,
    output logic          ien,
    output logic          busy,
    output logic          fin,
    output logic          cfg_bad
);
    localparam logic       WANT_DIR = IS_DST;
    localparam logic [1:0] PMAX     = 2'(MAX_PSIZE);

    ch_state_t     state_q, state_d;
    logic [AW-1:0] base_q, stride_q, cur_addr_q;
    logic [CW-1:0] cnt_q, cur_cnt_q;
    logic [OW-1:0] out_q;
    cfg_t          cfg_q, wcfg;
    logic          idle, cfg_wr, bad, start, accept, last_acc, drain_ok;

    assign wcfg     = cfg_t'(wdata[CFG_W-1:0]);
    assign idle     = (state_q == CH_IDLE);
    assign cfg_wr   = we && idle && (sel == SEL_CFG) && wcfg.en;
    assign bad      = (wcfg.psize > PMAX) || (wcfg.dir != WANT_DIR) || !wcfg.flow
                      || (IS_DST && (wcfg.psize != peer_psize));
    assign start    = cfg_wr && !bad;
    assign cfg_bad  = cfg_wr && bad;
    assign mem_req  = (state_q == CH_RUN) && (cur_cnt_q != '0) && xfer_ok
                      && (IS_DST || (out_q == '0));
    assign accept   = mem_req && mem_gnt;
    assign last_acc = accept && (cur_cnt_q == CW'(1));
    assign drain_ok = (IS_DST && !cfg_q.sync) || (out_q == '0);
    assign mem_addr = cur_addr_q;
    assign mem_size = cfg_q.msize;
    assign psize    = cfg_q.psize;
    assign ien      = cfg_q.irq_en;
    assign busy     = !idle;
    assign fin      = (state_q == CH_DONE);

    // register file: only writable while idle; enable drops at completion or on a rejected start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            stride_q <= '0;
            cfg_q    <= '0;
        end else begin
            if (we && idle) begin
                case (sel)
                    SEL_ADDR:   base_q   <= wdata[AW-1:0];
                    SEL_CNT:    cnt_q    <= wdata[CW-1:0];
                    SEL_STRIDE: stride_q <= wdata[AW-1:0];
                    SEL_CFG: begin
                        cfg_q <= wcfg;
                        if (bad) cfg_q.en <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (state_q == CH_DONE) cfg_q.en <= 1'b0;
        end
    end

    // address and count walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            cur_cnt_q  <= '0;
        end else if (start) begin
            cur_addr_q <= base_q;
            cur_cnt_q  <= cnt_q;
        end else if (accept) begin
            cur_addr_q <= cur_addr_q + stride_q;
            cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
    end

    // outstanding access counter: accepted requests minus responses
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_q + OW'(accept) - OW'(mem_resp);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        case (state_q)
            CH_IDLE:  if (start) state_d = CH_RUN;
            CH_RUN:   if (last_acc || (cur_cnt_q == '0)) state_d = CH_DRAIN;
            CH_DRAIN: if (drain_ok) state_d = CH_DONE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DONE) |=> (state_q == CH_IDLE));
    assert_addr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !idle && (sel == SEL_ADDR)) |=> (base_q == $past(base_q)));
    assert_count_spent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DRAIN) |-> (cur_cnt_q == '0));
    assert_sync_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_DST && (state_q == CH_DONE) && cfg_q.sync) |-> (out_q == '0));
    assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_DST |-> (out_q <= OW'(1)));
    assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (state_q == CH_IDLE));
endmodule

// File: rtl/mdma_pair.sv
// Memory-to-memory DMA pair: read channel -> FIFO -> write channel, plus sticky status.
// Assumes both channels are programmed with equal counts and that memory responses are in order.
module mdma_pair import mdma_pkg::*; #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int OW        = 8,
    parameter int DEPTH     = 4,
    parameter int MAX_PSIZE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_chan,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    input  logic          rd_gnt,
    input  logic          rd_valid,
    input  logic [31:0]   rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [31:0]   wr_data,
    input  logic          wr_gnt,
    input  logic          wr_ack,
    output logic          src_busy,
    output logic          dst_busy,
    output logic          done,
    output logic          cfg_err,
    output logic          irq
);
    logic       src_we, dst_we, stat_we;
    logic       f_full, f_empty, pop;
    logic [1:0] src_psize, dst_psize;
    logic       src_ien_unused, src_fin_unused, dst_ien, dst_fin;
    logic       src_bad, dst_bad;
    logic       done_q, err_q;

    assign stat_we = reg_we && (reg_sel == SEL_STAT);
    assign src_we  = reg_we && !reg_chan && !stat_we;
    assign dst_we  = reg_we &&  reg_chan && !stat_we;
    assign pop     = wr_req && wr_gnt;

    mdma_chan #(.AW(AW), .CW(CW), .OW(OW), .IS_DST(1'b0), .MAX_PSIZE(MAX_PSIZE)) u_src (
        .clk(clk), .rst_n(rst_n), .we(src_we), .sel(reg_sel), .wdata(reg_wdata),
        .peer_psize(dst_psize), .xfer_ok(!f_full), .mem_gnt(rd_gnt), .mem_resp(rd_valid),
        .mem_req(rd_req), .mem_addr(rd_addr), .mem_size(rd_size), .psize(src_psize),
        .ien(src_ien_unused), .busy(src_busy), .fin(src_fin_unused), .cfg_bad(src_bad)
    );

    mdma_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rd_valid), .pdata(rd_data), .pop(pop),
        .head(wr_data), .full(f_full), .empty(f_empty)
    );

    mdma_chan #(.AW(AW), .CW(CW), .OW(OW), .IS_DST(1'b1), .MAX_PSIZE(MAX_PSIZE)) u_dst (
        .clk(clk), .rst_n(rst_n), .we(dst_we), .sel(reg_sel), .wdata(reg_wdata),
        .peer_psize(src_psize), .xfer_ok(!f_empty), .mem_gnt(wr_gnt), .mem_resp(wr_ack),
        .mem_req(wr_req), .mem_addr(wr_addr), .mem_size(wr_size), .psize(dst_psize),
        .ien(dst_ien), .busy(dst_busy), .fin(dst_fin), .cfg_bad(dst_bad)
    );

    // sticky flags: set wins over a write-1-to-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (dst_fin)                         done_q <= 1'b1;
            else if (stat_we && reg_wdata[0])    done_q <= 1'b0;
            if (src_bad || dst_bad)              err_q  <= 1'b1;
            else if (stat_we && reg_wdata[1])    err_q  <= 1'b0;
        end
    end

    assign done    = done_q;
    assign cfg_err = err_q;
    assign irq     = done_q && dst_ien;

    assert_mismatch_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_bad |=> (cfg_err && !dst_busy));
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stat_we) |=> done);
endmodule

// File: tb/test_mdma_pair.sv
module test_mdma_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_chan = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_gnt = 1'b0, rd_valid = 1'b0, wr_gnt = 1'b0, wr_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        src_busy, dst_busy, done, cfg_err, irq;

    always #2 clk = ~clk;

    mdma_pair i_mdma_pair (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_gnt(wr_gnt),
        .wr_ack(wr_ack), .src_busy(src_busy), .dst_busy(dst_busy), .done(done),
        .cfg_err(cfg_err), .irq(irq)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    bit finished = 0;
    // expectation state shared with the memory model
    logic [31:0] sbase, dbase, sstr, dstr;
    logic [1:0]  ems;
    int  nrd = 0, nwr = 0, pend = 0, pend_at_done = 0;
    bit  done_seen = 0, slow = 0;
    int  rcnt = 0;
    logic [31:0] raddr = '0;
    int  due [64];
    int  qh = 0, qt = 0;

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and monitors, updated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid = 1'b0;
            if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) begin rd_valid = 1'b1; rd_data = pat(raddr); end
            end
            rd_gnt = (cyc % 3) != 1;
            if (rd_req && rd_gnt) begin
                chk(rd_addr == sbase + nrd * sstr, "R2 read addr", rd_addr, sbase + nrd * sstr);
                chk(rd_size == ems, "R2 read size", {30'd0, rd_size}, {30'd0, ems});
                raddr = rd_addr; rcnt = 2; nrd++;
            end
            wr_ack = 1'b0;
            if (qh != qt && due[qh % 64] <= cyc) begin wr_ack = 1'b1; qh++; pend--; end
            wr_gnt = slow ? ((cyc % 5) == 0) : ((cyc % 4) != 2);
            if (wr_req && wr_gnt) begin
                chk(wr_addr == dbase + nwr * dstr, "R2 write addr", wr_addr, dbase + nwr * dstr);
                chk(wr_data == pat(sbase + nwr * sstr), slow ? "R11 data under stall" : "R3 data order",
                    wr_data, pat(sbase + nwr * sstr));
                due[qt % 64] = cyc + 10; qt++; pend++; nwr++;
            end
            if (done && !done_seen) begin done_seen = 1; pend_at_done = pend; end
        end
    end

    task automatic wreg(bit ch, logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_chan = ch; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // cfg: bit0 en, bit1 dir, bit2 flow, [4:3] msize, [6:5] psize, bit7 sync, bit8 irq_en
    function automatic logic [31:0] cfgw(bit ien, bit sync, logic [1:0] ps, logic [1:0] ms, bit flow, bit dir);
        return {23'd0, ien, sync, ps, ms, flow, dir, 1'b1};
    endfunction

    task automatic run_xfer(int n, logic [1:0] ms, int smul, bit sync, bit ien);
        sbase = 32'h0000_1000 + 32'(n * 16);
        dbase = 32'h0004_0000 + 32'(ms * 256);
        sstr  = 32'(1 << ms);
        dstr  = 32'((1 << ms) * smul);
        ems   = ms;
        nrd = 0; nwr = 0; done_seen = 0;
        wreg(0, 3'd0, sbase); wreg(0, 3'd1, 32'(n)); wreg(0, 3'd2, sstr);
        wreg(0, 3'd3, cfgw(0, 0, 2'd1, ms, 1, 0));
        wreg(1, 3'd0, dbase); wreg(1, 3'd1, 32'(n)); wreg(1, 3'd2, dstr);
        @(negedge clk);
        reg_we = 1'b1; reg_chan = 1'b1; reg_sel = 3'd3; reg_wdata = cfgw(ien, sync, 2'd1, ms, 1, 1);
        @(negedge clk);
        reg_we = 1'b0;
        chk(dst_busy == 1'b1, "R4 enable starts", {31'd0, dst_busy}, 32'd1);
        // attempts to change address, count and stride while busy must not matter
        wreg(1, 3'd0, 32'hDEAD_0000); wreg(1, 3'd2, 32'd3); wreg(1, 3'd1, 32'd1);
        for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(nwr == n, "R1 write count", 32'(nwr), 32'(n));
        chk(nrd == n, "R1 read count", 32'(nrd), 32'(n));
        chk(nwr == n, "R9 locked regs kept count", 32'(nwr), 32'(n));
        chk(done == 1'b1, "R7 done set", {31'd0, done}, 32'd1);
        chk(irq == ien, "R8 irq gate", {31'd0, irq}, {31'd0, ien});
        chk(!src_busy && !dst_busy, "R10 idle after", {30'd0, src_busy, dst_busy}, 32'd0);
        if (sync) chk(pend_at_done == 0, "R6 sync waits acks", 32'(pend_at_done), 32'd0);
        else if (n > 0) chk(pend_at_done > 0, "R6 nosync early", 32'(pend_at_done), 32'd1);
        wreg(0, 3'd4, 32'd1);
        chk(done == 1'b0 && irq == 1'b0, "R7 W1C done", {30'd0, done, irq}, 32'd0);
        repeat (12) @(negedge clk);
    endtask

    task automatic bad_cfg(bit ch, logic [31:0] w, string tag);
        wreg(ch, 3'd1, 32'd0);
        wreg(ch, 3'd3, w);
        chk(cfg_err == 1'b1, tag, {31'd0, cfg_err}, 32'd1);
        chk((ch ? dst_busy : src_busy) == 1'b0, "R5 stays idle", {31'd0, ch ? dst_busy : src_busy}, 32'd0);
        wreg(0, 3'd4, 32'd2);
        chk(cfg_err == 1'b0, "R7 W1C cfg_err", {31'd0, cfg_err}, 32'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({src_busy, dst_busy, done, cfg_err, irq, rd_req, wr_req} == 7'd0, "R10 reset state",
            {25'd0, src_busy, dst_busy, done, cfg_err, irq, rd_req, wr_req}, 32'd0);
        for (int ms = 0; ms < 3; ms++)
            for (int ni = 0; ni < 6; ni++)
                for (int sy = 0; sy < 2; sy++) begin
                    int nv;
                    nv = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 2 : (ni == 3) ? 4 : (ni == 4) ? 7 : 13;
                    slow = (ni + sy) % 2 == 1;
                    run_xfer(nv, 2'(ms), 1 + sy, bit'(sy), bit'((ni + ms) % 2));
                end
        // read channel: source counts kept at zero so no data lingers in the FIFO
        wreg(0, 3'd1, 32'd0);
        wreg(0, 3'd3, cfgw(0, 0, 2'd1, 2'd0, 1, 0));
        repeat (4) @(negedge clk);
        bad_cfg(1, cfgw(0, 0, 2'd2, 2'd0, 1, 1), "R5 psize mismatch");
        bad_cfg(0, cfgw(0, 0, 2'd3, 2'd0, 1, 0), "R5 psize too big");
        bad_cfg(1, cfgw(0, 0, 2'd1, 2'd0, 1, 0), "R5 wrong dir");
        bad_cfg(0, cfgw(0, 0, 2'd1, 2'd0, 0, 0), "R5 flow not stop");
        summary();
    end
endmodule